// File: doc/BRIEF.md
# Presettable synchronous up/down decade-or-hex counter

This block is a four-bit synchronous counter whose sequence is chosen when it is built: either a decimal digit that runs 0 through 9, or a full binary nibble that runs 0 through 15. On each rising clock edge it either takes a new value from its four data inputs, steps one place up or down, or keeps its value. Two active-low enables must both be LOW before it counts. One is a local enable and the other is a chaining enable.

An active-low end-of-range flag is decoded directly from the register, the direction input and the chaining enable. It does not depend on the local enable. Several digits can therefore be cascaded by wiring each flag to the chaining enable of the next stage, with every stage on the same clock. In decimal mode, codes 10 to 15 can appear after a load. The counter finds its way back into the legal range within two enabled counts.

Top module: `updn_counter`

## Requirements
- R1: While `rst` is HIGH at a rising edge, `q` becomes 0. Reset takes priority over a load.
- R2: While `load_n` is LOW (and `rst` LOW), `q` takes `din` at the rising edge, whatever `cnt_par_n`, `cnt_trk_n` and `up` are.
- R3: With `load_n` HIGH, `q` changes only when both `cnt_par_n` and `cnt_trk_n` are LOW. If either one is HIGH, `q` holds.
- R4: When counting, `up` HIGH adds one and `up` LOW subtracts one. In binary mode (`DECADE`=0) the count wraps from 15 to 0 going up and from 0 to 15 going down.
- R5: In decimal mode (`DECADE`=1) the count wraps from 9 to 0 going up and from 0 to 9 going down.
- R6: `term_n` is LOW only while `cnt_trk_n` is LOW and `q` is at the end value for the current direction. The end value is 0 when `up` is LOW, and 15 (binary) or 9 (decimal) when `up` is HIGH. Otherwise `term_n` is HIGH.
- R7: `term_n` does not depend on `cnt_par_n`.
- R8: In decimal mode with `up` HIGH and `cnt_trk_n` LOW, `term_n` is also LOW for `q` = 11, 13 or 15.
- R9: In decimal mode, counting up maps 10→11, 12→13 and 14→15, and maps 11, 13 and 15→0. Counting down maps any code from 10 to 15 straight to 9. As a result, `q` is back in 0..9 within two enabled counts.
- R10: `term_n` is combinational, so it reaches the next stage in the same cycle. When two stages are cascaded, the upper stage steps exactly on the cycles in which the lower stage's `term_n` is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low parallel load |
| cnt_par_n | input | 1 | Active-low local count enable |
| cnt_trk_n | input | 1 | Active-low chaining count enable; also gates `term_n` |
| up | input | 1 | Direction: HIGH counts up, LOW counts down |
| din | input | 4 | Parallel load value |
| q | output | 4 | Counter state |
| term_n | output | 1 | Active-low end-of-range flag |

## Verification
The bench builds one instance with `DECADE`=0 and three with `DECADE`=1. The binary instance reaches the 15↔0 wraps. The decimal instances reach the 9↔0 wraps, every illegal code from 10 to 15 in both directions, and the extra flag decodes on 11, 13 and 15. Two of the decimal instances form a cascaded pair. Over long up and down runs they show the upper digit stepping only on the lower digit's flag. Scripted phases cover load priority, holds with each enable HIGH, and the flag with the local enable HIGH. These are followed by pseudo-random input traffic, checked against a reference model.

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter bit DECADE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_n,
  input  logic       cnt_par_n,
  input  logic       cnt_trk_n,
  input  logic       up,
  input  logic [3:0] din,
  output logic [3:0] q,
  output logic       term_n
);
  localparam logic [3:0] LAST = DECADE ? 4'd9 : 4'd15;

  logic       cnt_en;
  logic       odd_bad;
  logic       at_end;
  logic [3:0] nxt;

  assign cnt_en  = !cnt_par_n && !cnt_trk_n;
  assign odd_bad = DECADE && (q > LAST) && q[0];

  always_comb begin
    if (up)
      nxt = (q == LAST || odd_bad) ? 4'd0 : q + 4'd1;
    else
      nxt = (q == 4'd0 || q > LAST) ? LAST : q - 4'd1;
  end

  assign at_end = up ? (q == LAST || odd_bad) : (q == 4'd0);
  assign term_n = !(!cnt_trk_n && at_end);

  always_ff @(posedge clk) begin
    if (rst)          q <= 4'd0;
    else if (!load_n) q <= din;
    else if (cnt_en)  q <= nxt;
  end

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> q == $past(din));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && (cnt_par_n || cnt_trk_n)) |=> $stable(q));

  a_r6_trk_blocks_flag: assert property (@(posedge clk) disable iff (rst)
    cnt_trk_n |-> term_n);

  generate
    if (DECADE) begin : g_dec
      a_r5_legal_stays_legal: assert property (@(posedge clk) disable iff (rst)
        (load_n && q <= 4'd9) |=> q <= 4'd9);
      a_r9_down_recovers: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en && !up && q > 4'd9) |=> q == 4'd9);
    end else begin : g_bin
      a_r4_up_steps: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en && up) |=> q == 4'($past(q) + 4'd1));
      a_r4_down_steps: assert property (@(posedge clk) disable iff (rst)
        (load_n && cnt_en && !up) |=> q == 4'($past(q) - 4'd1));
    end
  endgenerate
endmodule

// File: tb/tb_updn_counter.sv
module tb_updn_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic b_ld, b_par, b_trk, b_up; logic [3:0] b_din; logic [3:0] b_q; logic b_tc;
  logic d_ld, d_par, d_trk, d_up; logic [3:0] d_din; logic [3:0] d_q; logic d_tc;
  logic c_ld, c_par, c_trk, c_up; logic [3:0] c_dlo, c_dhi;
  logic [3:0] lo_q, hi_q; logic lo_tc, hi_tc;

  updn_counter #(.DECADE(1'b0)) dut (.clk(clk), .rst(rst), .load_n(b_ld), .cnt_par_n(b_par),
    .cnt_trk_n(b_trk), .up(b_up), .din(b_din), .q(b_q), .term_n(b_tc));
  updn_counter #(.DECADE(1'b1)) u_dec (.clk(clk), .rst(rst), .load_n(d_ld), .cnt_par_n(d_par),
    .cnt_trk_n(d_trk), .up(d_up), .din(d_din), .q(d_q), .term_n(d_tc));
  updn_counter #(.DECADE(1'b1)) u_lo (.clk(clk), .rst(rst), .load_n(c_ld), .cnt_par_n(c_par),
    .cnt_trk_n(c_trk), .up(c_up), .din(c_dlo), .q(lo_q), .term_n(lo_tc));
  updn_counter #(.DECADE(1'b1)) u_hi (.clk(clk), .rst(rst), .load_n(c_ld), .cnt_par_n(c_par),
    .cnt_trk_n(lo_tc), .up(c_up), .din(c_dhi), .q(hi_q), .term_n(hi_tc));

  typedef struct {
    string req;
    logic [3:0] bq, dq, lq, hq;
  } exp_t;
  exp_t sb[$];

  int tests = 0, fails = 0;
  logic [3:0] mb, md, ml, mh;

  function automatic logic [3:0] ref_next(bit dec, logic [3:0] s, logic r, logic ld,
      logic par, logic trk, logic u, logic [3:0] d);
    logic [3:0] top;
    top = dec ? 4'd9 : 4'd15;
    if (r) return 4'd0;
    if (!ld) return d;
    if (par || trk) return s;
    if (u) begin
      if (s == top) return 4'd0;
      if (dec && (s == 4'd11 || s == 4'd13 || s == 4'd15)) return 4'd0;
      return s + 4'd1;
    end
    if (s == 4'd0) return top;
    if (dec && s >= 4'd10) return 4'd9;
    return s - 4'd1;
  endfunction

  function automatic logic ref_tc(bit dec, logic [3:0] s, logic trk, logic u);
    logic hit;
    if (u) hit = dec ? (s == 4'd9 || s == 4'd11 || s == 4'd13 || s == 4'd15) : (s == 4'd15);
    else   hit = (s == 4'd0);
    return !(hit && !trk);
  endfunction

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(string req);
    exp_t e;
    logic hi_trk;
    hi_trk = ref_tc(1'b1, ml, c_trk, c_up);
    e.req = req;
    e.bq = ref_next(1'b0, mb, rst, b_ld, b_par, b_trk, b_up, b_din);
    e.dq = ref_next(1'b1, md, rst, d_ld, d_par, d_trk, d_up, d_din);
    e.lq = ref_next(1'b1, ml, rst, c_ld, c_par, c_trk, c_up, c_dlo);
    e.hq = ref_next(1'b1, mh, rst, c_ld, c_par, hi_trk, c_up, c_dhi);
    sb.push_back(e);
    mb = e.bq; md = e.dq; ml = e.lq; mh = e.hq;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "bin q", b_q, e.bq);
        check(e.req, "dec q", d_q, e.dq);
        check(e.req, "lo q", lo_q, e.lq);
        check(e.req, "hi q", hi_q, e.hq);
        check(e.req, "bin term_n", {3'd0, b_tc}, {3'd0, ref_tc(1'b0, mb, b_trk, b_up)});
        check(e.req, "dec term_n", {3'd0, d_tc}, {3'd0, ref_tc(1'b1, md, d_trk, d_up)});
        check("R10", "lo term_n", {3'd0, lo_tc}, {3'd0, ref_tc(1'b1, ml, c_trk, c_up)});
        check("R10", "hi term_n", {3'd0, hi_tc},
              {3'd0, ref_tc(1'b1, mh, ref_tc(1'b1, ml, c_trk, c_up), c_up)});
      end
    end
  end

  task automatic all_ctl(logic ld, logic par, logic trk, logic u);
    b_ld = ld; b_par = par; b_trk = trk; b_up = u;
    d_ld = ld; d_par = par; d_trk = trk; d_up = u;
    c_ld = ld; c_par = par; c_trk = trk; c_up = u;
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    mb = 4'd0; md = 4'd0; ml = 4'd0; mh = 4'd0;
    rst = 1'b1;
    all_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    b_din = 4'd5; d_din = 4'd5; c_dlo = 4'd3; c_dhi = 4'd4;
    @(negedge clk);
    tick("R1"); tick("R1");
    rst = 1'b0;

    // R2: load with enables high and both directions
    all_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    b_din = 4'd14; d_din = 4'd8; c_dlo = 4'd7; c_dhi = 4'd9;
    tick("R2");
    // R4 R5 R10: count up across the wraps
    all_ctl(1'b1, 1'b0, 1'b0, 1'b1);
    repeat (4) tick("R4");
    // count down across the wraps
    all_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (6) tick("R5");
    // R3: hold with each enable high
    all_ctl(1'b1, 1'b1, 1'b0, 1'b1);
    repeat (2) tick("R3");
    all_ctl(1'b1, 1'b0, 1'b1, 1'b0);
    repeat (2) tick("R3");
    // R7: flag at terminal with local enable high
    all_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    b_din = 4'd15; d_din = 4'd9; c_dlo = 4'd9; c_dhi = 4'd2;
    tick("R2");
    all_ctl(1'b1, 1'b1, 1'b0, 1'b1);
    repeat (2) tick("R7");
    all_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    tick("R7");
    // R6: load 0 and watch the down flag
    all_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    b_din = 4'd0; d_din = 4'd0;
    tick("R6");
    all_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    tick("R6");
    all_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    tick("R6");

    // R8 R9: every illegal decimal code, both directions
    for (int code = 10; code < 16; code++) begin
      for (int dir = 0; dir < 2; dir++) begin
        all_ctl(1'b0, 1'b1, 1'b1, dir[0]);
        d_din = 4'(code); b_din = 4'(code);
        tick("R9");
        all_ctl(1'b1, 1'b1, 1'b0, dir[0]);
        tick("R8");
        all_ctl(1'b1, 1'b0, 1'b0, dir[0]);
        tick("R9"); tick("R9");
        check("R9", "dec in range after two counts", {3'd0, d_q > 4'd9}, 4'd0);
      end
    end

    // R10: long cascade runs
    all_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    c_dlo = 4'd0; c_dhi = 4'd0;
    tick("R10");
    all_ctl(1'b1, 1'b0, 1'b0, 1'b1);
    repeat (120) tick("R10");
    all_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (130) tick("R10");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      b_ld = (r[2:0] != 3'd0); b_par = r[3] & r[4]; b_trk = r[5] & r[6]; b_up = r[7];
      d_ld = (r[10:8] != 3'd0); d_par = r[11] & r[4]; d_trk = r[12] & r[6]; d_up = r[13];
      c_ld = (r[15:13] != 3'd0); c_par = r[14] & r[3]; c_trk = r[9] & r[5]; c_up = r[1];
      b_din = 4'($urandom); d_din = 4'($urandom); c_dlo = 4'($urandom); c_dhi = 4'($urandom);
      tick("R3");
    end
    finish_run();
  end
endmodule